// File: doc/BRIEF.md
# Two-Page Associative Address Translator

This block is a fully associative translation buffer. Each slot covers a naturally aligned pair of pages: one tag, one page-size mask, an address-space identifier, a global flag and a hardware-invalidate flag are shared by the pair. Each page of the pair has its own frame address and four attribute bits: valid, writable (dirty), read-inhibit and execute-inhibit. A lookup presents a virtual address, the current address-space identifier and the access kind (instruction fetch, data load or data store). One cycle later the block returns a result code, the physical address and the read and write permissions.

A slot hits when the address agrees with its tag above the masked offset, its hardware-invalidate flag is clear, and it is either global or owned by the current address space. The width of that identifier compare is chosen at run time by a compare-mask input, so both narrow and wide identifiers work from one build. The page of the pair is chosen by the highest address bit inside the slot mask. Slots are loaded through a simple indexed write port. Replacement choice and refill belong to the surrounding logic.

Top module: `assoc_tlb`

## Requirements
- R1: A slot hits only when (va XOR tag) is zero in every bit where its mask is 0, its hardware-invalidate flag is clear, and either its global flag is set or (asid XOR slot asid) AND the compare mask is zero. With no hitting slot the result code is 1 (no match).
- R2: The page of the pair is the value of the address bit set in the mask but not in the mask shifted right by one: 0 selects the even frame and attributes, 1 the odd ones.
- R3: After a hit the selected attributes (bit 0 valid, bit 1 dirty, bit 2 read-inhibit, bit 3 execute-inhibit) are checked in this order: valid clear gives code 2; a fetch (kind 0) with execute-inhibit gives code 5; a load (kind 1, and kind 3 which is treated as a load) with read-inhibit gives code 4; a store (kind 2) with dirty clear gives code 3; otherwise code 0.
- R4: On code 0 the physical address is the selected frame address ORed with the address bits covered by the mask shifted right by one.
- R5: On code 0 read permission is 1 and write permission equals the selected dirty bit; on any other code the physical address, read and write permission are all 0.
- R6: Only identifier bits set in the compare-mask input take part in the identifier compare.
- R7: When several slots hit, the one with the lowest index decides the result.
- R8: A request sampled at a clock edge is answered at that edge: the response-valid output is high for exactly the following cycle, and result outputs hold their values while no request is made.
- R9: A write takes effect at the clock edge where it is sampled; a lookup sampled at that same edge sees the slot contents from before the write. Writes to an index at or above the slot count are ignored.
- R10: Reset marks every slot hardware-invalid, so lookups return code 1, and resets the outputs to code 1, zero address, no permissions and no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| asid_cmp_mask | input | ASID_W | Bits of the identifier that take part in the compare |
| wr_en | input | 1 | Load the slot at wr_idx |
| wr_idx | input | IDX_W | Slot index to load |
| wr_tag | input | VA_W | Virtual tag of the pair |
| wr_mask | input | VA_W | Page mask, ones over the pair offset |
| wr_asid | input | ASID_W | Owning address-space identifier |
| wr_global | input | 1 | Slot matches any identifier |
| wr_hinv | input | 1 | Slot disabled by hardware invalidate |
| wr_pfn_even | input | PA_W | Frame address of the even page |
| wr_pfn_odd | input | PA_W | Frame address of the odd page |
| wr_attr_even | input | 4 | Even attributes {xinh, rinh, dirty, valid} |
| wr_attr_odd | input | 4 | Odd attributes {xinh, rinh, dirty, valid} |
| lk_req | input | 1 | Lookup request |
| lk_va | input | VA_W | Virtual address |
| lk_asid | input | ASID_W | Current address-space identifier |
| lk_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 load |
| rsp_vld | output | 1 | Response for the previous cycle's request |
| rsp_code | output | 3 | 0 ok, 1 no match, 2 invalid, 3 dirty, 4 read-inhibit, 5 execute-inhibit |
| rsp_pa | output | PA_W | Physical address |
| rsp_rd | output | 1 | Read allowed |
| rsp_wr | output | 1 | Write allowed |

## Verification
The two functions that can share a cycle are a slot load and a lookup that hits the very slot being loaded. The bench provokes this by raising the write enable and the lookup request at the same edge for one index whose old and new contents give different codes and frame addresses. The response is judged against the model state from before the write, and a follow-up lookup on the next cycle must then reflect the new contents.

// File: rtl/assoc_tlb_pkg.sv
package assoc_tlb_pkg;

   typedef enum logic [2:0] {
      XC_OK      = 3'd0,
      XC_MISS    = 3'd1,
      XC_INVALID = 3'd2,
      XC_DIRTY   = 3'd3,
      XC_RDINH   = 3'd4,
      XC_EXINH   = 3'd5
   } xl_code_e;

   typedef enum logic [1:0] {
      AK_FETCH = 2'd0,
      AK_LOAD  = 2'd1,
      AK_STORE = 2'd2,
      AK_LOAD2 = 2'd3
   } acc_kind_e;

   typedef struct packed {
      logic xinh;
      logic rinh;
      logic dirty;
      logic valid;
   } half_attr_t;

endpackage

// File: rtl/tlb_tag_cmp.sv
module tlb_tag_cmp #(
   parameter int VA_W   = 32,
   parameter int ASID_W = 16
) (
   input  logic [VA_W-1:0]   va,
   input  logic [ASID_W-1:0] asid,
   input  logic [ASID_W-1:0] asid_mask,
   input  logic [VA_W-1:0]   ent_tag,
   input  logic [VA_W-1:0]   ent_mask,
   input  logic [ASID_W-1:0] ent_asid,
   input  logic              ent_global,
   input  logic              ent_hinv,
   output logic              hit
);

   logic tag_eq;
   logic id_eq;

   always_comb begin
      tag_eq = (((va ^ ent_tag) & ~ent_mask) == '0);
      id_eq  = ent_global || (((asid ^ ent_asid) & asid_mask) == '0);
      hit    = tag_eq && id_eq && !ent_hinv;
   end

endmodule

// File: rtl/tlb_first_hit.sv
module tlb_first_hit #(
   parameter int N     = 16,
   parameter int IDX_W = 4
) (
   input  logic [N-1:0]     hits,
   output logic             any,
   output logic [IDX_W-1:0] idx
);

   always_comb begin
      any = |hits;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (hits[i]) idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/tlb_access_judge.sv
module tlb_access_judge
   import assoc_tlb_pkg::*;
(
   input  logic       any_hit,
   input  half_attr_t attr,
   input  acc_kind_e  kind,
   output xl_code_e   code,
   output logic       rd_ok,
   output logic       wr_ok
);

   logic is_fetch;
   logic is_load;
   logic is_store;

   always_comb begin
      is_fetch = (kind == AK_FETCH);
      is_store = (kind == AK_STORE);
      is_load  = (kind == AK_LOAD) || (kind == AK_LOAD2);
      rd_ok    = 1'b0;
      wr_ok    = 1'b0;
      if (!any_hit)                    code = XC_MISS;
      else if (!attr.valid)            code = XC_INVALID;
      else if (is_fetch && attr.xinh)  code = XC_EXINH;
      else if (is_load && attr.rinh)   code = XC_RDINH;
      else if (is_store && !attr.dirty) code = XC_DIRTY;
      else begin
         code  = XC_OK;
         rd_ok = 1'b1;
         wr_ok = attr.dirty;
      end
   end

endmodule

// File: rtl/assoc_tlb.sv
module assoc_tlb
   import assoc_tlb_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int VA_W    = 32,
   parameter int PA_W    = 32,
   parameter int ASID_W  = 16,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ASID_W-1:0] asid_cmp_mask,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [VA_W-1:0]   wr_tag,
   input  logic [VA_W-1:0]   wr_mask,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic              wr_global,
   input  logic              wr_hinv,
   input  logic [PA_W-1:0]   wr_pfn_even,
   input  logic [PA_W-1:0]   wr_pfn_odd,
   input  logic [3:0]        wr_attr_even,
   input  logic [3:0]        wr_attr_odd,
   input  logic              lk_req,
   input  logic [VA_W-1:0]   lk_va,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic [1:0]        lk_kind,
   output logic              rsp_vld,
   output logic [2:0]        rsp_code,
   output logic [PA_W-1:0]   rsp_pa,
   output logic              rsp_rd,
   output logic              rsp_wr
);

   // elaboration-time parameter checks
   if (ENTRIES < 2 || ENTRIES > 256) begin : g_bad_entries
      $error("assoc_tlb: ENTRIES out of range");
   end
   if (VA_W < 14 || PA_W < 14) begin : g_bad_width
      $error("assoc_tlb: address widths too small");
   end
   if (ASID_W < 8) begin : g_bad_asid
      $error("assoc_tlb: identifier narrower than 8 bits");
   end

   // slot storage
   logic [VA_W-1:0]   tag_q   [ENTRIES];
   logic [VA_W-1:0]   mask_q  [ENTRIES];
   logic [ASID_W-1:0] asid_q  [ENTRIES];
   logic              glob_q  [ENTRIES];
   logic              hinv_q  [ENTRIES];
   logic [PA_W-1:0]   pfn_q   [ENTRIES][2];
   half_attr_t        attr_q  [ENTRIES][2];

   logic wr_in_range;
   assign wr_in_range = (32'(wr_idx) < ENTRIES);

   for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
      logic wr_here;
      assign wr_here = wr_en && wr_in_range && (wr_idx == IDX_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tag_q[e]     <= '0;
            mask_q[e]    <= '0;
            asid_q[e]    <= '0;
            glob_q[e]    <= 1'b0;
            hinv_q[e]    <= 1'b1;
            pfn_q[e][0]  <= '0;
            pfn_q[e][1]  <= '0;
            attr_q[e][0] <= '0;
            attr_q[e][1] <= '0;
         end else if (wr_here) begin
            tag_q[e]     <= wr_tag;
            mask_q[e]    <= wr_mask;
            asid_q[e]    <= wr_asid;
            glob_q[e]    <= wr_global;
            hinv_q[e]    <= wr_hinv;
            pfn_q[e][0]  <= wr_pfn_even;
            pfn_q[e][1]  <= wr_pfn_odd;
            attr_q[e][0] <= half_attr_t'(wr_attr_even);
            attr_q[e][1] <= half_attr_t'(wr_attr_odd);
         end
      end
   end

   // parallel compare
   logic [ENTRIES-1:0] hit_vec;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      tlb_tag_cmp #(
         .VA_W   (VA_W),
         .ASID_W (ASID_W)
      ) u_cmp (
         .va         (lk_va),
         .asid       (lk_asid),
         .asid_mask  (asid_cmp_mask),
         .ent_tag    (tag_q[e]),
         .ent_mask   (mask_q[e]),
         .ent_asid   (asid_q[e]),
         .ent_global (glob_q[e]),
         .ent_hinv   (hinv_q[e]),
         .hit        (hit_vec[e])
      );
   end

   logic             any_hit;
   logic [IDX_W-1:0] sel_idx;

   tlb_first_hit #(
      .N     (ENTRIES),
      .IDX_W (IDX_W)
   ) u_pick (
      .hits (hit_vec),
      .any  (any_hit),
      .idx  (sel_idx)
   );

   // page-of-pair selection and address forming
   logic [VA_W-1:0] sel_mask;
   logic [VA_W-1:0] half_off_mask;
   logic            sel_odd;
   half_attr_t      sel_attr;
   logic [PA_W-1:0] sel_pfn;
   logic [PA_W-1:0] pa_c;

   always_comb begin
      sel_mask      = mask_q[sel_idx];
      half_off_mask = sel_mask >> 1;
      sel_odd       = |(lk_va & sel_mask & ~half_off_mask);
      sel_attr      = attr_q[sel_idx][sel_odd];
      sel_pfn       = pfn_q[sel_idx][sel_odd];
      pa_c          = sel_pfn | PA_W'(lk_va & half_off_mask);
   end

   xl_code_e code_c;
   logic     rd_c;
   logic     wr_c;

   tlb_access_judge u_judge (
      .any_hit (any_hit),
      .attr    (sel_attr),
      .kind    (acc_kind_e'(lk_kind)),
      .code    (code_c),
      .rd_ok   (rd_c),
      .wr_ok   (wr_c)
   );

   // response register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_vld  <= 1'b0;
         rsp_code <= XC_MISS;
         rsp_pa   <= '0;
         rsp_rd   <= 1'b0;
         rsp_wr   <= 1'b0;
      end else begin
         rsp_vld <= lk_req;
         if (lk_req) begin
            rsp_code <= code_c;
            rsp_pa   <= (code_c == XC_OK) ? pa_c : '0;
            rsp_rd   <= rd_c;
            rsp_wr   <= wr_c;
         end
      end
   end

endmodule

// File: rtl/assoc_tlb_chk.sv
module assoc_tlb_chk #(
   parameter int PA_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            lk_req,
   input logic [1:0]      lk_kind,
   input logic            rsp_vld,
   input logic [2:0]      rsp_code,
   input logic [PA_W-1:0] rsp_pa,
   input logic            rsp_rd,
   input logic            rsp_wr
);

   p_resp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req |=> rsp_vld);

   p_resp_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_req |=> !rsp_vld);

   p_resp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_req |=> ($stable(rsp_code) && $stable(rsp_pa) && $stable(rsp_wr)));

   p_fail_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_code != 3'd0) |-> (!rsp_rd && !rsp_wr && rsp_pa == '0));

   p_ok_reads_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld && rsp_code == 3'd0) |-> rsp_rd);

   p_store_ok_writes_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_req && lk_kind == 2'd2) |=> (rsp_code != 3'd0 || rsp_wr));

   p_dirty_store_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_req && lk_kind != 2'd2) |=> (rsp_code != 3'd3));

   p_exinh_fetch_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_req && lk_kind != 2'd0) |=> (rsp_code != 3'd5));

   p_rdinh_load_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_req && (lk_kind == 2'd0 || lk_kind == 2'd2)) |=> (rsp_code != 3'd4));

   p_code_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_code <= 3'd5);

endmodule

bind assoc_tlb assoc_tlb_chk #(.PA_W(PA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .lk_req   (lk_req),
   .lk_kind  (lk_kind),
   .rsp_vld  (rsp_vld),
   .rsp_code (rsp_code),
   .rsp_pa   (rsp_pa),
   .rsp_rd   (rsp_rd),
   .rsp_wr   (rsp_wr)
);

// File: tb/assoc_tlb_test.sv
module assoc_tlb_test;

   localparam int N = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] asid_cmp_mask = 16'h00FF;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_idx = '0;
   logic [31:0] wr_tag = '0, wr_mask = '0;
   logic [15:0] wr_asid = '0;
   logic        wr_global = 1'b0, wr_hinv = 1'b0;
   logic [31:0] wr_pfn_even = '0, wr_pfn_odd = '0;
   logic [3:0]  wr_attr_even = '0, wr_attr_odd = '0;
   logic        lk_req = 1'b0;
   logic [31:0] lk_va = '0;
   logic [15:0] lk_asid = '0;
   logic [1:0]  lk_kind = '0;
   logic        rsp_vld;
   logic [2:0]  rsp_code;
   logic [31:0] rsp_pa;
   logic        rsp_rd, rsp_wr;

   always #10 clk = ~clk;

   assoc_tlb uut (
      .clk(clk), .rst_n(rst_n), .asid_cmp_mask(asid_cmp_mask),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_mask(wr_mask),
      .wr_asid(wr_asid), .wr_global(wr_global), .wr_hinv(wr_hinv),
      .wr_pfn_even(wr_pfn_even), .wr_pfn_odd(wr_pfn_odd),
      .wr_attr_even(wr_attr_even), .wr_attr_odd(wr_attr_odd),
      .lk_req(lk_req), .lk_va(lk_va), .lk_asid(lk_asid), .lk_kind(lk_kind),
      .rsp_vld(rsp_vld), .rsp_code(rsp_code), .rsp_pa(rsp_pa),
      .rsp_rd(rsp_rd), .rsp_wr(rsp_wr)
   );

   // model state
   logic [31:0] m_tag [N], m_mask [N], m_pfn0 [N], m_pfn1 [N];
   logic [15:0] m_asid [N];
   logic        m_glob [N], m_hinv [N];
   logic [3:0]  m_at0 [N], m_at1 [N];

   int checks = 0;
   int errors = 0;
   bit done = 0;

   task automatic check(string req, logic [63:0] got, logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, got, exp);
      end
   endtask

   // result packed as {code, rd, wr, pa}
   function automatic logic [36:0] ref_lookup(logic [31:0] va, logic [15:0] asid,
                                               logic [1:0] kind);
      for (int i = 0; i < N; i++) begin
         if (!m_hinv[i] && ((va & ~m_mask[i]) == (m_tag[i] & ~m_mask[i])) &&
             (m_glob[i] || ((asid & asid_cmp_mask) == (m_asid[i] & asid_cmp_mask)))) begin
            logic [31:0] top = m_mask[i] & ~(m_mask[i] >> 1);
            logic        odd = ((va & top) != 0);
            logic [3:0]  at  = odd ? m_at1[i] : m_at0[i];
            logic [31:0] pfn = odd ? m_pfn1[i] : m_pfn0[i];
            if (!at[0])                                 return {3'd2, 2'b00, 32'h0};
            if (kind == 2'd0 && at[3])                  return {3'd5, 2'b00, 32'h0};
            if ((kind == 2'd1 || kind == 2'd3) && at[2]) return {3'd4, 2'b00, 32'h0};
            if (kind == 2'd2 && !at[1])                 return {3'd3, 2'b00, 32'h0};
            return {3'd0, 1'b1, at[1], pfn | (va & (m_mask[i] >> 1))};
         end
      end
      return {3'd1, 2'b00, 32'h0};
   endfunction

   task automatic model_write(int idx, logic [31:0] tag, logic [31:0] mask,
                              logic [15:0] asid, logic glob, logic hinv,
                              logic [31:0] p0, logic [31:0] p1,
                              logic [3:0] a0, logic [3:0] a1);
      if (idx < N) begin
         m_tag[idx] = tag;   m_mask[idx] = mask; m_asid[idx] = asid;
         m_glob[idx] = glob; m_hinv[idx] = hinv;
         m_pfn0[idx] = p0;   m_pfn1[idx] = p1;
         m_at0[idx] = a0;    m_at1[idx] = a1;
      end
   endtask

   task automatic drive_write(int idx, logic [31:0] tag, logic [31:0] mask,
                              logic [15:0] asid, logic glob, logic hinv,
                              logic [31:0] p0, logic [31:0] p1,
                              logic [3:0] a0, logic [3:0] a1);
      wr_en = 1'b1; wr_idx = idx[3:0]; wr_tag = tag; wr_mask = mask;
      wr_asid = asid; wr_global = glob; wr_hinv = hinv;
      wr_pfn_even = p0; wr_pfn_odd = p1; wr_attr_even = a0; wr_attr_odd = a1;
   endtask

   task automatic put(int idx, logic [31:0] tag, logic [31:0] mask,
                      logic [15:0] asid, logic glob, logic hinv,
                      logic [31:0] p0, logic [31:0] p1,
                      logic [3:0] a0, logic [3:0] a1);
      @(negedge clk);
      drive_write(idx, tag, mask, asid, glob, hinv, p0, p1, a0, a1);
      @(negedge clk);
      wr_en = 1'b0;
      model_write(idx, tag, mask, asid, glob, hinv, p0, p1, a0, a1);
   endtask

   task automatic look(string req, logic [31:0] va, logic [15:0] asid, logic [1:0] kind);
      logic [36:0] exp;
      exp = ref_lookup(va, asid, kind);
      @(negedge clk);
      lk_req = 1'b1; lk_va = va; lk_asid = asid; lk_kind = kind;
      @(negedge clk);
      lk_req = 1'b0;
      check({req, " response valid"}, 64'(rsp_vld), 64'd1);
      check(req, 64'({rsp_code, rsp_rd, rsp_wr, rsp_pa}), 64'(exp));
   endtask

   function automatic logic [31:0] pick_mask(int s);
      case (s % 5)
         0: return 32'h0000_1FFF;
         1: return 32'h0000_7FFF;
         2: return 32'h0001_FFFF;
         3: return 32'h0007_FFFF;
         default: return 32'h001F_FFFF;
      endcase
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL R8 watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd5150));
      for (int i = 0; i < N; i++)
         model_write(i, '0, '0, '0, 1'b0, 1'b1, '0, '0, '0, '0);
      repeat (3) @(negedge clk);
      // R10: reset state of outputs
      check("R10 reset code", 64'(rsp_code), 64'd1);
      check("R10 reset vld", 64'(rsp_vld), 64'd0);
      check("R10 reset perms", 64'({rsp_rd, rsp_wr, rsp_pa}), 64'd0);
      rst_n = 1'b1;
      // R10: every slot invalid after reset
      look("R10 lookup after reset", 32'h0000_0000, 16'h0, 2'd1);
      look("R10 lookup after reset", 32'h1234_5000, 16'h0, 2'd0);

      // R2/R4/R5: even and odd pages of a 4K pair
      put(0, 32'h0040_2000, 32'h0000_1FFF, 16'h0011, 1'b0, 1'b0,
          32'hAAA0_0000, 32'hBBB0_0000, 4'b0011, 4'b0001);
      look("R2 R4 even page load", 32'h0040_2ABC, 16'h0011, 2'd1);
      look("R2 R4 odd page load", 32'h0040_3ABC, 16'h0011, 2'd1);
      look("R5 store to clean odd page", 32'h0040_3004, 16'h0011, 2'd2);
      look("R5 store to dirty even page", 32'h0040_2004, 16'h0011, 2'd2);
      look("R1 identifier mismatch", 32'h0040_2004, 16'h0012, 2'd1);
      look("R1 tag mismatch", 32'h0040_4004, 16'h0011, 2'd1);

      // R3: priority of the attribute checks
      put(1, 32'h0100_0000, 32'h0000_7FFF, 16'h0000, 1'b1, 1'b0,
          32'h0200_0000, 32'h0300_0000, 4'b1101, 4'b1100);
      look("R3 fetch exec-inhibit", 32'h0100_0010, 16'h0055, 2'd0);
      look("R3 load read-inhibit", 32'h0100_0010, 16'h0055, 2'd1);
      look("R3 kind3 as load", 32'h0100_0010, 16'h0055, 2'd3);
      look("R3 store not dirty", 32'h0100_0010, 16'h0055, 2'd2);
      look("R3 invalid beats inhibits", 32'h0100_4010, 16'h0055, 2'd0);
      look("R3 invalid on store", 32'h0100_4010, 16'h0055, 2'd2);

      // R1: hardware-invalidate flag
      put(2, 32'h0900_0000, 32'h0000_1FFF, 16'h0000, 1'b1, 1'b1,
          32'h0A00_0000, 32'h0B00_0000, 4'b0011, 4'b0011);
      look("R1 hinv slot ignored", 32'h0900_0010, 16'h0000, 2'd1);

      // R6: identifier compare mask
      put(3, 32'h0500_0000, 32'h0000_1FFF, 16'h1234, 1'b0, 1'b0,
          32'h0600_0000, 32'h0700_0000, 4'b0011, 4'b0011);
      asid_cmp_mask = 16'h00FF;
      look("R6 narrow compare hits", 32'h0500_0100, 16'h5634, 2'd1);
      asid_cmp_mask = 16'hFFFF;
      look("R6 wide compare misses", 32'h0500_0100, 16'h5634, 2'd1);
      look("R6 wide compare hits", 32'h0500_0100, 16'h1234, 2'd1);

      // R7: lowest index wins
      put(7, 32'h0C00_0000, 32'h0000_1FFF, 16'h0000, 1'b1, 1'b0,
          32'h7770_0000, 32'h7780_0000, 4'b0011, 4'b0011);
      put(5, 32'h0C00_0000, 32'h0000_1FFF, 16'h0000, 1'b1, 1'b0,
          32'h5550_0000, 32'h5560_0000, 4'b0001, 4'b0001);
      look("R7 lowest index decides", 32'h0C00_0020, 16'h0000, 2'd2);
      look("R7 lowest index frame", 32'h0C00_1020, 16'h0000, 2'd1);

      // R9: write and lookup on the same edge
      begin
         logic [36:0] exp_old;
         exp_old = ref_lookup(32'h0C00_0040, 16'h0000, 2'd2);
         @(negedge clk);
         drive_write(5, 32'h0C00_0000, 32'h0000_1FFF, 16'h0000, 1'b1, 1'b0,
                     32'h9990_0000, 32'h9980_0000, 4'b0011, 4'b0011);
         lk_req = 1'b1; lk_va = 32'h0C00_0040; lk_asid = 16'h0; lk_kind = 2'd2;
         @(negedge clk);
         wr_en = 1'b0; lk_req = 1'b0;
         check("R9 same-edge lookup sees old slot",
               64'({rsp_code, rsp_rd, rsp_wr, rsp_pa}), 64'(exp_old));
         model_write(5, 32'h0C00_0000, 32'h0000_1FFF, 16'h0000, 1'b1, 1'b0,
                     32'h9990_0000, 32'h9980_0000, 4'b0011, 4'b0011);
         look("R9 next lookup sees new slot", 32'h0C00_0040, 16'h0000, 2'd2);
      end

      // R8: no request -> no response, outputs held
      begin
         logic [36:0] held;
         held = {rsp_code, rsp_rd, rsp_wr, rsp_pa};
         @(negedge clk);
         lk_va = 32'h0900_0000; lk_kind = 2'd0;
         @(negedge clk);
         check("R8 idle no response", 64'(rsp_vld), 64'd0);
         check("R8 idle outputs held", 64'({rsp_code, rsp_rd, rsp_wr, rsp_pa}), 64'(held));
      end

      // random fill and lookups (R1 to R7)
      for (int i = 0; i < N; i++) begin
         logic [31:0] m = pick_mask(int'($urandom % 5));
         put(i, $urandom & ~m, m, 16'($urandom % 3), ($urandom % 4) == 0,
             ($urandom % 8) == 0, $urandom, $urandom,
             4'($urandom), 4'($urandom));
      end
      for (int k = 0; k < 400; k++) begin
         int e = int'($urandom % N);
         logic [31:0] va = (m_tag[e] & ~m_mask[e]) | ($urandom & m_mask[e]);
         if (k % 7 == 0) va = $urandom;
         asid_cmp_mask = (k % 2 == 0) ? 16'h00FF : 16'hFFFF;
         look("R1 R3 R4 R7 random", va, 16'($urandom % 3) | ((k % 3 == 0) ? 16'h0100 : 16'h0),
              2'($urandom));
      end

      // R9: write beyond slot count ignored (all indices valid for 16, rewrite check)
      look("R9 final state", m_tag[0] & ~m_mask[0], m_asid[0], 2'd1);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule